// File: doc/BRIEF.md
# Masked XOR Space Compactor

This block reduces the number of scan outputs a tester must watch. It takes one bit from each internal scan chain in every unload shift cycle. It folds groups of chains into a smaller set of output channels through balanced XOR trees. Each chain has a mask bit that decides whether the chain takes part in its channel's XOR. When exactly one chain per channel is left unmasked, that channel carries the chain's raw bit stream. A failing chain can then be isolated and its fault signature read straight off the channel.

Each channel also has an on-block comparator. In every shift cycle it checks the channel bit against an expected bit from the tester. Any mismatch sets a sticky fail flag for that channel, so a pass or fail verdict per channel is available once the unload ends. The mask is loaded serially through a single-bit port between unloads.

Top module: `masked_xor_compactor`

## Requirements
- R1: While `rst` is high at a clock edge, `ch_out` and `ch_fail` become all zeros and every mask bit becomes 1, so every chain is observed.
- R2: Channel j is assigned chains j*RATIO through j*RATIO+RATIO-1. Its value is the XOR of the `chain_bits` of those chains whose mask bit is 1. A chain whose mask bit is 0 contributes logic 0.
- R3: When exactly one chain of a channel has its mask bit set, that channel's output equals that chain's bit in every shift cycle, whatever the other chains of the group carry.
- R4: `ch_out` is registered. At the edge that ends a cycle with `shift_en` high, it takes the channel values computed from that cycle's `chain_bits`. In cycles with `shift_en` low it holds its value.
- R5: A cycle with `mask_ld_en` high and `shift_en` low shifts the mask one place toward chain 0 and writes `mask_ld_bit` into the mask bit of chain NUM_CH*RATIO-1. After NUM_CH*RATIO such cycles, the first bit loaded controls chain 0. A mask bit of 1 means the chain is observed.
- R6: `mask_ld_en` has no effect in a cycle with `shift_en` high. Neither the mask nor the fail flags change because of it.
- R7: In a shift cycle, if channel j's computed value differs from `exp_bits[j]`, `ch_fail[j]` is 1 from the following edge on.
- R8: A set `ch_fail` bit stays set until reset or until a mask load cycle as defined in R5, which clears all fail flags.
- R9: When one chain is observed alone and stuck at 0 while its expected stream is 11001100, the channel unloads all zeros and that channel's fail flag is set. The fail flag of a channel whose observed chain is healthy stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_bits | input | NUM_CH*RATIO | One scan-out bit per chain for the current cycle |
| shift_en | input | 1 | Marks an unload shift cycle |
| exp_bits | input | NUM_CH | Expected channel bits for the current shift cycle |
| mask_ld_en | input | 1 | Serial mask load strobe |
| mask_ld_bit | input | 1 | Serial mask data bit |
| ch_out | output | NUM_CH | Registered compacted channel bits |
| ch_fail | output | NUM_CH | Sticky per-channel mismatch flags |

## Verification
The hardest situation to reach from the ports is a mask load strobe that coincides with a shift cycle while a fail flag is already set. Only then can a wrongly accepted load be seen, either as a cleared flag or as a shifted mask. The stimulus first sets a fail flag through a deliberate expected-bit mismatch. It then asserts the load strobe during shifts. Later shifts through the one-hot mask show that the selection did not move and the flag survived. A stuck-at-0 chain under a one-hot mask, checked against the 11001100 stream, confirms that isolation works end to end.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
  // Number of nodes in a complete binary XOR tree with n leaves
  function automatic int tree_nodes(input int n);
    return 2 * n - 1;
  endfunction
endpackage

// File: rtl/cmpx_mask_reg.sv
module cmpx_mask_reg #(
  parameter int NCHAIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_take,
  input  logic              ld_bit,
  output logic [NCHAIN-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '1;
    else if (ld_take)
      mask_q <= {ld_bit, mask_q[NCHAIN-1:1]};
  end
endmodule

// File: rtl/cmpx_xor_tree.sv
module cmpx_xor_tree
  import cmpx_pkg::*;
#(
  parameter int RATIO = 4
) (
  input  logic [RATIO-1:0] din,
  input  logic [RATIO-1:0] msk,
  output logic             dout
);
  localparam int NODES = tree_nodes(RATIO);

  // Heap-ordered tree: leaves at RATIO-1 .. NODES-1, root at 0
  logic [NODES-1:0] node;

  for (genvar k = 0; k < RATIO; k++) begin : g_leaf
    assign node[RATIO-1+k] = din[k] & msk[k];
  end

  for (genvar i = 0; i < RATIO-1; i++) begin : g_inner
    assign node[i] = node[2*i+1] ^ node[2*i+2];
  end

  assign dout = node[0];
endmodule

// File: rtl/cmpx_fail_trk.sv
module cmpx_fail_trk #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic [NUM_CH-1:0] ch_val,
  input  logic [NUM_CH-1:0] exp_val,
  output logic [NUM_CH-1:0] fail_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      fail_q <= '0;
    else if (shift)
      fail_q <= fail_q | (ch_val ^ exp_val);
  end
endmodule

// File: rtl/masked_xor_compactor.sv
module masked_xor_compactor #(
  parameter int NUM_CH = 2,
  parameter int RATIO  = 4,
  localparam int NCHAIN = NUM_CH * RATIO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCHAIN-1:0] chain_bits,
  input  logic              shift_en,
  input  logic [NUM_CH-1:0] exp_bits,
  input  logic              mask_ld_en,
  input  logic              mask_ld_bit,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] ch_fail
);
  logic [NCHAIN-1:0] mask_q;
  logic [NUM_CH-1:0] ch_comb;
  logic              ld_take;

  // Loads are accepted only between shift cycles
  assign ld_take = mask_ld_en & ~shift_en;

  cmpx_mask_reg #(.NCHAIN(NCHAIN)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .ld_take (ld_take),
    .ld_bit  (mask_ld_bit),
    .mask_q  (mask_q)
  );

  for (genvar j = 0; j < NUM_CH; j++) begin : g_ch
    cmpx_xor_tree #(.RATIO(RATIO)) u_tree (
      .din  (chain_bits[j*RATIO +: RATIO]),
      .msk  (mask_q[j*RATIO +: RATIO]),
      .dout (ch_comb[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      ch_out <= '0;
    else if (shift_en)
      ch_out <= ch_comb;
  end

  cmpx_fail_trk #(.NUM_CH(NUM_CH)) u_fail (
    .clk     (clk),
    .rst     (rst),
    .clr     (ld_take),
    .shift   (shift_en),
    .ch_val  (ch_comb),
    .exp_val (exp_bits),
    .fail_q  (ch_fail)
  );
endmodule

// File: rtl/cmpx_sva.sv
module cmpx_sva #(
  parameter int NUM_CH = 2,
  parameter int NCHAIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_en,
  input logic              mask_ld_en,
  input logic [NUM_CH-1:0] ch_out,
  input logic [NUM_CH-1:0] ch_fail,
  input logic [NCHAIN-1:0] mask_q
);
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ch_out));

  // R6
  mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(mask_q));

  // R7
  fail_rise_on_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ((ch_fail & ~$past(ch_fail)) == '0));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(mask_ld_en && !shift_en) |=> ((ch_fail & $past(ch_fail)) == $past(ch_fail)));

  // R8
  fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_ld_en && !shift_en) |=> (ch_fail == '0));
endmodule

bind masked_xor_compactor cmpx_sva #(.NUM_CH(NUM_CH), .NCHAIN(NCHAIN)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .shift_en   (shift_en),
  .mask_ld_en (mask_ld_en),
  .ch_out     (ch_out),
  .ch_fail    (ch_fail),
  .mask_q     (mask_q)
);

// File: tb/sim_masked_xor_compactor.sv
`timescale 1ns/1ps
module sim_masked_xor_compactor;
  localparam int NUM_CH = 2;
  localparam int RATIO  = 4;
  localparam int NCHAIN = NUM_CH * RATIO;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCHAIN-1:0] chain_bits = '0;
  logic              shift_en = 1'b0;
  logic [NUM_CH-1:0] exp_bits = '0;
  logic              mask_ld_en = 1'b0;
  logic              mask_ld_bit = 1'b0;
  logic [NUM_CH-1:0] ch_out;
  logic [NUM_CH-1:0] ch_fail;

  always #10 clk = ~clk;

  masked_xor_compactor #(.NUM_CH(NUM_CH), .RATIO(RATIO)) u0 (
    .clk(clk), .rst(rst), .chain_bits(chain_bits), .shift_en(shift_en),
    .exp_bits(exp_bits), .mask_ld_en(mask_ld_en), .mask_ld_bit(mask_ld_bit),
    .ch_out(ch_out), .ch_fail(ch_fail)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit m_mask [NCHAIN];
  bit m_out  [NUM_CH];
  bit m_fail [NUM_CH];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] pack_out();
    logic [NUM_CH-1:0] v;
    for (int j = 0; j < NUM_CH; j++) v[j] = m_out[j];
    return v;
  endfunction

  function automatic logic [NUM_CH-1:0] pack_fail();
    logic [NUM_CH-1:0] v;
    for (int j = 0; j < NUM_CH; j++) v[j] = m_fail[j];
    return v;
  endfunction

  // expected channel value from the current reference mask
  function automatic logic [NUM_CH-1:0] ref_chan(input logic [NCHAIN-1:0] cb);
    logic [NUM_CH-1:0] v;
    for (int j = 0; j < NUM_CH; j++) begin
      int ones = 0;
      for (int k = 0; k < RATIO; k++)
        if (m_mask[j*RATIO+k] && cb[j*RATIO+k]) ones++;
      v[j] = (ones % 2 == 1);
    end
    return v;
  endfunction

  // one clock: drive, update the reference after the edge, compare at negedge
  task automatic cycle(input string tag, input logic sh, input logic [NCHAIN-1:0] cb,
                       input logic [NUM_CH-1:0] ex, input logic ld, input logic lb);
    logic [NUM_CH-1:0] cv;
    shift_en = sh; chain_bits = cb; exp_bits = ex; mask_ld_en = ld; mask_ld_bit = lb;
    cv = ref_chan(cb);
    @(posedge clk);
    if (sh) begin
      for (int j = 0; j < NUM_CH; j++) begin
        m_out[j] = cv[j];
        if (cv[j] != ex[j]) m_fail[j] = 1;
      end
    end else if (ld) begin
      for (int k = 0; k < NCHAIN-1; k++) m_mask[k] = m_mask[k+1];
      m_mask[NCHAIN-1] = lb;
      for (int j = 0; j < NUM_CH; j++) m_fail[j] = 0;
    end
    @(negedge clk);
    check({tag, " ch_out"}, 32'(ch_out), 32'(pack_out()));
    check({tag, " ch_fail"}, 32'(ch_fail), 32'(pack_fail()));
  endtask

  task automatic load_mask(input logic [NCHAIN-1:0] m);
    for (int k = 0; k < NCHAIN; k++)
      cycle("R5 load", 1'b0, NCHAIN'($urandom), '0, 1'b1, m[k]);
  endtask

  initial begin
    for (int k = 0; k < NCHAIN; k++) m_mask[k] = 1;
    for (int j = 0; j < NUM_CH; j++) begin m_out[j] = 0; m_fail[j] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ch_out", 32'(ch_out), 0);
    check("R1 ch_fail", 32'(ch_fail), 0);
    // R1 all-observe mask: single set bit reaches channel 0
    cycle("R1 mask", 1'b1, 8'h01, 2'b01, 1'b0, 1'b0);
    check("R1 single", 32'(ch_out), 32'h1);
    // R2 full compaction with random data, matching expectations
    for (int n = 0; n < 20; n++) begin
      logic [NCHAIN-1:0] cb = NCHAIN'($urandom);
      cycle("R2", 1'b1, cb, ref_chan(cb), 1'b0, 1'b0);
    end
    check("R2 parity", 32'(ch_fail), 0);
    // R7 deliberate mismatch on channel 1
    cycle("R7", 1'b1, 8'h30, 2'b10, 1'b0, 1'b0);
    check("R7 flag", 32'(ch_fail), 32'h2);
    // R4 hold with moving data
    for (int n = 0; n < 4; n++)
      cycle("R4", 1'b0, NCHAIN'($urandom), 2'b11, 1'b0, 1'b0);
    // R8 sticky through matching shifts
    for (int n = 0; n < 4; n++) begin
      logic [NCHAIN-1:0] cb = NCHAIN'($urandom);
      cycle("R8 sticky", 1'b1, cb, ref_chan(cb), 1'b0, 1'b0);
    end
    check("R8 still set", 32'(ch_fail), 32'h2);
    // R5 load one-hot: chain 2 on channel 0, chain 5 on channel 1
    load_mask(8'b0010_0100);
    check("R8 cleared", 32'(ch_fail), 0);
    // R3 observed chain passes through; others random
    for (int n = 0; n < 12; n++) begin
      logic [NCHAIN-1:0] cb = NCHAIN'($urandom);
      cycle("R3", 1'b1, cb, {cb[5], cb[2]}, 1'b0, 1'b0);
      check("R3 ch0", 32'(ch_out[0]), 32'(cb[2]));
      check("R3 ch1", 32'(ch_out[1]), 32'(cb[5]));
    end
    // R6 set a flag, then strobe loads during shifts
    cycle("R6 setup", 1'b1, 8'h04, 2'b00, 1'b0, 1'b0);
    for (int n = 0; n < 10; n++) begin
      logic [NCHAIN-1:0] cb = NCHAIN'($urandom);
      cycle("R6", 1'b1, cb, {cb[5], cb[2]}, 1'b1, 1'b1);
    end
    check("R6 flag kept", 32'(ch_fail), 32'h1);
    begin
      logic [NCHAIN-1:0] cb = 8'b1101_1011;
      cycle("R6 mask kept", 1'b1, cb, 2'b00, 1'b0, 1'b0);
      check("R6 mask kept", 32'(ch_out), 32'h0);
    end
    // R9 stuck-at-0 on chain 2 versus 11001100, chain 5 healthy
    load_mask(8'b0010_0100);
    begin
      logic [7:0] pat = 8'b1100_1100;
      for (int n = 7; n >= 0; n--) begin
        logic [NCHAIN-1:0] cb = NCHAIN'($urandom);
        cb[2] = 1'b0;
        cb[5] = pat[n];
        cycle("R9", 1'b1, cb, {pat[n], pat[n]}, 1'b0, 1'b0);
        check("R9 zero out", 32'(ch_out[0]), 0);
      end
    end
    check("R9 flags", 32'(ch_fail), 32'h1);
    // R1 reset again clears flags
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset flags", 32'(ch_fail), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule